// File: doc/BRIEF.md
# Window Pulse Discriminator

This block watches a slow signal through two level-detector bits: an upper bit that is high above the top threshold, and a lower bit that is high above the bottom threshold. It raises a flag when the signal has made an excursion that crossed the bottom threshold and came back below it without ever reaching the top threshold. The flag rises once the excursion is over. It stays up while the signal rests below the bottom threshold, and it clears as soon as the signal climbs past the bottom threshold again.

Both detector bits come from outside the clock domain. Each passes through a synchronizer of `SYNC_STAGES` flops and is then classified once per cycle. The level code is written {up, lo}. Codes 00, 01 and 11 are legal. Code 10 cannot occur on a sound detector pair. A four-state registered machine follows the level code. It is encoded so that exactly one state bit flips on every transition, and the flag is the AND of the two state bits, so the flag cannot glitch.

Top module: `wdisc_top`

## Requirements
- R1: While rst_ni is low, and right after it rises, state_o is 2'b10 (overshoot) and hit_o is 0. An excursion already in progress at reset cannot set hit_o until level code 00 has been seen.
- R2: A change on up_i/lo_i reaches state_o and hit_o exactly SYNC_STAGES+1 rising edges later (3 for the default).
- R3: The level codes 00, then 01, then 00 move the state through idle (2'b00), inside (2'b01) and success (2'b11), and hit_o goes to 1 on the return to 00.
- R4: hit_o stays 1 while the code stays 00. It clears when the code becomes 01, and the state becomes inside (2'b01), which starts a new excursion.
- R5: A code 11 from idle or success goes straight to overshoot (2'b10). From inside it passes through idle (2'b00) for one cycle and then reaches overshoot. hit_o is 0 throughout.
- R6: In overshoot, the codes 01 and 11 keep the state. Only code 00 leaves, and it leads to idle.
- R7: The illegal code 10 leaves the state and hit_o unchanged in every state.
- R8: The state encoding is idle 00, inside 01, overshoot 10, success 11. hit_o is the AND of both state bits. state_o never changes more than one bit between consecutive cycles.
- R9: In idle, a code 01 whose preceding legal code was 11 leads to overshoot, not inside. This way the one-cycle idle step of R5 cannot forget the overshoot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Upper-threshold detector bit, asynchronous |
| lo_i | input | 1 | Lower-threshold detector bit, asynchronous |
| hit_o | output | 1 | In-window pulse flag |
| state_o | output | 2 | Machine state, for debug |

## Verification
The checker relies on the level code after the synchronizer. It assumes that the upper bit is high only while the lower bit is high, except for the deliberate code 10 that tests R7. It also assumes that the level normally moves one threshold at a time. The stimulus holds every code for several cycles, well beyond the synchronizer latency, so each transition settles before the next one. The only exceptions are two deliberate jumps between 00 and 11 and a single-cycle 11 pulse that exercises the idle step of R5 and R9.

// File: rtl/wdisc_pkg.sv
package wdisc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_INSIDE = 2'b01,
    ST_OVER   = 2'b10,
    ST_HIT    = 2'b11
  } wd_state_e;

  // level code = {up, lo}
  typedef enum logic [1:0] {
    LV_BELOW  = 2'b00,
    LV_WINDOW = 2'b01,
    LV_BAD    = 2'b10,
    LV_ABOVE  = 2'b11
  } wd_level_e;
endpackage

// File: rtl/wdisc_sync.sv
module wdisc_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdisc_hist.sv
module wdisc_hist
  import wdisc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wd_level_e level_i,
  output logic      legal_o,
  output logic      above_last_o
);
  logic last_up_q;

  assign legal_o = (level_i != LV_BAD);

  // upper bit of the last legal code; reset pessimistically to "above"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_up_q <= 1'b1;
    else if (legal_o) last_up_q <= level_i[1];
  end

  assign above_last_o = last_up_q;
endmodule

// File: rtl/wdisc_fsm.sv
module wdisc_fsm
  import wdisc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wd_level_e level_i,
  input  logic      legal_i,
  input  logic      above_last_i,
  output wd_state_e state_o
);
  wd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (legal_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (level_i == LV_ABOVE)       state_d = ST_OVER;
          else if (level_i == LV_WINDOW) state_d = above_last_i ? ST_OVER : ST_INSIDE;
        end
        ST_INSIDE: begin
          if (level_i == LV_BELOW)      state_d = ST_HIT;
          else if (level_i == LV_ABOVE) state_d = ST_IDLE; // single-bit step toward overshoot
        end
        ST_HIT: begin
          if (level_i == LV_WINDOW)     state_d = ST_INSIDE;
          else if (level_i == LV_ABOVE) state_d = ST_OVER;
        end
        ST_OVER: begin
          if (level_i == LV_BELOW)      state_d = ST_IDLE;
        end
        default: state_d = ST_OVER;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OVER;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/wdisc_top.sv
module wdisc_top
  import wdisc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       up_i,
  input  logic       lo_i,
  output logic       hit_o,
  output logic [1:0] state_o
);
  localparam int LVL_W = 2;

  logic [LVL_W-1:0] lvl_sync;
  wd_level_e        level;
  logic             legal;
  logic             above_last;
  wd_state_e        state;

  wdisc_sync #(
    .WIDTH  (LVL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LVL_W'(LV_ABOVE))
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({up_i, lo_i}),
    .q_o   (lvl_sync)
  );

  assign level = wd_level_e'(lvl_sync);

  wdisc_hist u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (level),
    .legal_o     (legal),
    .above_last_o(above_last)
  );

  wdisc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (level),
    .legal_i     (legal),
    .above_last_i(above_last),
    .state_o     (state)
  );

  assign state_o = state;
  assign hit_o   = state[1] & state[0];
endmodule

// File: rtl/wdisc_chk.sv
module wdisc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] lvl_i,
  input logic [1:0] state_i,
  input logic       hit_i
);
  a_r8_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_i ^ $past(state_i)) <= 1);

  a_r3_success: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b01 && lvl_i == 2'b00) |=> (state_i == 2'b11 && hit_i));

  a_r4_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b11 && lvl_i == 2'b01) |=> (state_i == 2'b01 && !hit_i));

  a_r5_over_from_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b11 && lvl_i == 2'b11) |=> (state_i == 2'b10));

  a_r5_inside_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b01 && lvl_i == 2'b11) |=> (state_i == 2'b00));

  a_r6_over_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b10 && lvl_i != 2'b00) |=> (state_i == 2'b10));

  a_r7_illegal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == 2'b10) |=> $stable(state_i));
endmodule

bind wdisc_top wdisc_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .lvl_i  (lvl_sync),
  .state_i(state_o),
  .hit_i  (hit_o)
);

// File: tb/tb_wdisc_top.sv
`timescale 1ns/1ps
module tb_wdisc_top;
  localparam int HOLD = 6;
  localparam int NVEC = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up = 1'b0, lo = 1'b1;
  logic       hit;
  logic [1:0] st;
  int         n_chk = 0, n_err = 0, n_flip = 0;
  logic [1:0] prev_st = 2'b10;

  always #2.5 clk = ~clk;

  wdisc_top dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .up_i   (up),
    .lo_i   (lo),
    .hit_o  (hit),
    .state_o(st)
  );

  // {code{up,lo}, hit, state}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b01_0_10, // R1 excursion at reset ignored
    5'b00_0_00, // R6
    5'b01_0_01, // R3
    5'b00_1_11, // R3
    5'b01_0_01, // R4
    5'b00_1_11, // R3 second pulse
    5'b01_0_01, // R4
    5'b11_0_10, // R5
    5'b01_0_10, // R6
    5'b00_0_00, // R6
    5'b01_0_01,
    5'b10_0_01, // R7
    5'b00_1_11,
    5'b10_1_11, // R7
    5'b00_1_11, // R4
    5'b01_0_01,
    5'b11_0_10, // R5
    5'b01_0_10, // R6
    5'b00_0_00,
    5'b11_0_10, // R5 from idle
    5'b00_0_00,
    5'b01_0_01,
    5'b00_1_11,
    5'b11_0_10, // R5 from success
    5'b00_0_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] code, input int cyc);
    @(negedge clk);
    {up, lo} = code;
    repeat (cyc - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst_n) prev_st <= 2'b10;
    else begin
      if ($countones(st ^ prev_st) > 1) n_flip++;
      prev_st <= st;
    end
  end

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(st == 2'b10, "R1 reset state", st, 2);
    chk(hit == 1'b0, "R1 reset hit", hit, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][4:3], HOLD);
      chk(hit == VEC[i][2], $sformatf("R3/R4/R5/R6/R7 vec %0d hit", i), hit, VEC[i][2]);
      chk(st == VEC[i][1:0], $sformatf("R3/R4/R5/R6/R7 vec %0d state", i), st, VEC[i][1:0]);
    end

    // R2 latency: idle -> inside, then return below
    drive(2'b01, HOLD);
    @(negedge clk);
    {up, lo} = 2'b00;
    @(negedge clk);
    @(negedge clk);
    chk(hit == 1'b0, "R2 hit before latency", hit, 0);
    @(negedge clk);
    chk(hit == 1'b1, "R2 hit at latency", hit, 1);

    // R9: one-cycle overshoot from inside must not be forgotten
    drive(2'b01, HOLD);
    drive(2'b11, 1);
    drive(2'b01, HOLD);
    chk(st == 2'b10, "R9 state after short overshoot", st, 2);
    chk(hit == 1'b0, "R9 hit after short overshoot", hit, 0);
    drive(2'b00, HOLD);
    chk(st == 2'b00 && hit == 1'b0, "R9 return lands idle", st, 0);

    // R1 asynchronous reset during an excursion
    drive(2'b01, HOLD);
    chk(st == 2'b01, "R1 pre-reset inside", st, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(st == 2'b10 && hit == 1'b0, "R1 async reset", st, 2);
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'b00, HOLD);
    chk(hit == 1'b0, "R1 no hit from pre-reset excursion", hit, 0);
    drive(2'b01, HOLD);
    drive(2'b00, HOLD);
    chk(hit == 1'b1, "R1 recovery pulse", hit, 1);

    chk(n_flip == 0, "R8 multi-bit state steps", n_flip, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule